// File: doc/BRIEF.md
# Manchester Line Encoder with Pre-emphasis Taps

This block turns a serial NRZ transmit stream into 10 Mb/s Manchester code. It runs from a 20 MHz reference clock, and it hands the controller a 10 MHz transmit clock made by dividing that reference by two. Each bit period is two half-bits of one reference period (50 ns) each. A data 1 is sent as low then high. A data 0 is sent as high then low. The shortest line pulse is therefore one half-bit and the longest is one full bit.

The block drives four digital lines:
- a true line;
- its complement;
- a delayed copy of the true line;
- a delayed copy of the complement.

Board resistors sum the true line with the delayed complement, and the complement with the delayed true line. This boosts the short pulses that a twisted pair attenuates most. A static mode pin picks the idle convention: either a constant positive differential or zero differential.

Bits enter through a valid/ready pair. The encoder asserts `tx_ready` for exactly one reference cycle per bit period, in the last cycle of the second half-bit. A bit is taken at a clock edge where `tx_valid` and `tx_ready` are both high. The source keeps `tx_valid` and `tx_data` steady until that edge and must not make `tx_valid` depend on `tx_ready`. Back-pressure is therefore fixed by the line rate: the source waits at most one bit period. If `tx_valid` is low at a ready edge, the frame ends. The bit in flight completes and the lines return to idle.

Top module: `manchester_pe_tx`

## Requirements
- R1: `tx_clk` has a period of 2*HALF_CYC reference cycles (default: the 20 MHz reference divided by two). It is low during the first half-bit and high during the second, so it falls right after each bit boundary.
- R2: `tx_ready` is high for one reference cycle per bit period, only while `tx_clk` is high. A bit is accepted at an edge where `tx_valid` and `tx_ready` are both high.
- R3: An accepted 1 drives `drv_p` low for the first half-bit and high for the second. An accepted 0 drives `drv_p` high then low. The first half-bit begins in the cycle right after the accepting edge.
- R4: While a bit is on the line, `drv_n` is the inverse of `drv_p`. The two are equal only when idle with `idle_mode` high.
- R5: When idle with `idle_mode` low, `drv_p` is 1 and `drv_n` is 0 (positive differential).
- R6: When idle with `idle_mode` high, `drv_p` and `drv_n` are both 0 (zero differential).
- R7: `drv_pd` and `drv_nd` repeat `drv_p` and `drv_n` delayed by DLY_TAPS reference periods (default 1, which is 50 ns).
- R8: `tx_valid` and `tx_data` are ignored while `tx_ready` is low. Dropping `tx_valid` mid-bit lets that bit finish both halves before the idle level returns, at the next bit boundary.
- R9: During and right after reset, `tx_clk` and `tx_ready` are 0. `drv_p` and `drv_pd` are 1, and `drv_n` and `drv_nd` are 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | 20 MHz reference clock |
| rst_n | input | 1 | Asynchronous reset, active low |
| idle_mode | input | 1 | Idle convention: 0 = positive differential, 1 = zero differential |
| tx_valid | input | 1 | Source has a bit to send (transmit enable) |
| tx_data | input | 1 | NRZ bit offered with `tx_valid` |
| tx_ready | output | 1 | Encoder takes a bit at this edge |
| tx_clk | output | 1 | 10 MHz transmit clock to the controller |
| drv_p | output | 1 | True line drive |
| drv_n | output | 1 | Complement line drive |
| drv_pd | output | 1 | True line delayed for pre-emphasis |
| drv_nd | output | 1 | Complement line delayed for pre-emphasis |

## Verification
The encoder is driven with a mixed bit string:
- Runs of equal bits give full-bit-wide pulses at the boundaries.
- Alternating bits give half-bit pulses, which separate a swapped half order from a missing boundary transition.

A frame that drops `tx_valid` mid-bit while flipping `tx_data` shows that the bit in flight finishes unchanged and that the idle level returns only at the boundary. Idle periods in both modes, and a frame sent in zero-differential mode, separate the idle convention from the complementary data drive. Every cycle, the delayed lines are compared with the main lines seen one cycle earlier.

// File: rtl/manchester_pe_pkg.sv
package manchester_pe_pkg;

  typedef struct packed {
    logic p;
    logic n;
  } line_pair_t;

  localparam line_pair_t LINE_IDLE_POS  = '{p: 1'b1, n: 1'b0};
  localparam line_pair_t LINE_IDLE_ZERO = '{p: 1'b0, n: 1'b0};

  function automatic line_pair_t idle_level(input logic zero_diff);
    return zero_diff ? LINE_IDLE_ZERO : LINE_IDLE_POS;
  endfunction

  function automatic line_pair_t data_level(input logic bit_val, input logic second_half);
    line_pair_t lv;
    lv.p = second_half ? bit_val : ~bit_val;
    lv.n = ~lv.p;
    return lv;
  endfunction

endpackage

// File: rtl/manchester_pe_phase.sv
module manchester_pe_phase #(
  parameter int HALF_CYC = 1
) (
  input  logic clk,
  input  logic rst_n,
  output logic half_sel,
  output logic bit_end
);
  localparam int CW = (HALF_CYC > 1) ? $clog2(HALF_CYC) : 1;
  localparam logic [CW-1:0] LAST = CW'(HALF_CYC - 1);

  logic [CW-1:0] cnt;
  logic          half_end;

  assign half_end = (cnt == LAST);
  assign bit_end  = half_end & half_sel;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      cnt      <= '0;
      half_sel <= 1'b0;
    end else if (half_end) begin
      cnt      <= '0;
      half_sel <= ~half_sel;
    end else begin
      cnt      <= cnt + 1'b1;
    end
  end
endmodule

// File: rtl/manchester_pe_sampler.sv
module manchester_pe_sampler (
  input  logic clk,
  input  logic rst_n,
  input  logic bit_end,
  input  logic tx_valid,
  input  logic tx_data,
  output logic tx_ready,
  output logic active,
  output logic cur_bit
);
  assign tx_ready = bit_end;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      active  <= 1'b0;
      cur_bit <= 1'b0;
    end else if (bit_end) begin
      active <= tx_valid;
      if (tx_valid) cur_bit <= tx_data;
    end
  end
endmodule

// File: rtl/manchester_pe_coder.sv
module manchester_pe_coder
  import manchester_pe_pkg::*;
(
  input  logic       active,
  input  logic       cur_bit,
  input  logic       half_sel,
  input  logic       idle_mode,
  output line_pair_t lvl
);
  always_comb begin
    if (active) lvl = data_level(cur_bit, half_sel);
    else        lvl = idle_level(idle_mode);
  end
endmodule

// File: rtl/manchester_pe_delay.sv
module manchester_pe_delay
  import manchester_pe_pkg::*;
#(
  parameter int TAPS = 1
) (
  input  logic       clk,
  input  logic       rst_n,
  input  line_pair_t din,
  output line_pair_t dout
);
  line_pair_t stage [TAPS];

  for (genvar i = 0; i < TAPS; i++) begin : g_tap
    if (i == 0) begin : g_first
      always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) stage[i] <= LINE_IDLE_POS;
        else        stage[i] <= din;
      end
    end else begin : g_next
      always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) stage[i] <= LINE_IDLE_POS;
        else        stage[i] <= stage[i-1];
      end
    end
  end

  assign dout = stage[TAPS-1];
endmodule

// File: rtl/manchester_pe_tx.sv
module manchester_pe_tx
  import manchester_pe_pkg::*;
#(
  parameter int HALF_CYC = 1,
  parameter int DLY_TAPS = 1
) (
  input  logic clk,
  input  logic rst_n,
  input  logic idle_mode,
  input  logic tx_valid,
  input  logic tx_data,
  output logic tx_ready,
  output logic tx_clk,
  output logic drv_p,
  output logic drv_n,
  output logic drv_pd,
  output logic drv_nd
);
  logic       half_sel;
  logic       bit_end;
  logic       active;
  logic       cur_bit;
  line_pair_t lvl;
  line_pair_t lvl_dly;

  manchester_pe_phase #(.HALF_CYC(HALF_CYC)) u_phase (
    .clk(clk), .rst_n(rst_n), .half_sel(half_sel), .bit_end(bit_end)
  );

  manchester_pe_sampler u_sampler (
    .clk(clk), .rst_n(rst_n), .bit_end(bit_end),
    .tx_valid(tx_valid), .tx_data(tx_data),
    .tx_ready(tx_ready), .active(active), .cur_bit(cur_bit)
  );

  manchester_pe_coder u_coder (
    .active(active), .cur_bit(cur_bit), .half_sel(half_sel),
    .idle_mode(idle_mode), .lvl(lvl)
  );

  manchester_pe_delay #(.TAPS(DLY_TAPS)) u_delay (
    .clk(clk), .rst_n(rst_n), .din(lvl), .dout(lvl_dly)
  );

  assign tx_clk = half_sel;
  assign drv_p  = lvl.p;
  assign drv_n  = lvl.n;
  assign drv_pd = lvl_dly.p;
  assign drv_nd = lvl_dly.n;
endmodule

// File: rtl/manchester_pe_tx_chk.sv
module manchester_pe_tx_chk #(
  parameter int DLY_TAPS = 1
) (
  input logic clk,
  input logic rst_n,
  input logic idle_mode,
  input logic tx_valid,
  input logic tx_data,
  input logic tx_ready,
  input logic tx_clk,
  input logic drv_p,
  input logic drv_n,
  input logic drv_pd,
  input logic drv_nd
);
  localparam int WW = $clog2(DLY_TAPS + 1) + 1;

  logic [DLY_TAPS-1:0] hist_p;
  logic [DLY_TAPS-1:0] hist_n;
  logic [WW-1:0]       warm;
  logic                warm_ok;

  assign warm_ok = (warm >= WW'(DLY_TAPS));

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      hist_p <= '0;
      hist_n <= '0;
      warm   <= '0;
    end else begin
      for (int i = DLY_TAPS - 1; i > 0; i--) begin
        hist_p[i] <= hist_p[i-1];
        hist_n[i] <= hist_n[i-1];
      end
      hist_p[0] <= drv_p;
      hist_n[0] <= drv_n;
      if (!warm_ok) warm <= warm + 1'b1;
    end
  end

  AST_CLK_FALLS_AFTER_BOUNDARY: assert property (@(posedge clk) disable iff (!rst_n)
    tx_ready |=> !tx_clk); // R1
  AST_READY_IN_SECOND_HALF: assert property (@(posedge clk) disable iff (!rst_n)
    tx_ready |-> tx_clk); // R2
  AST_FIRST_HALF_LEVEL: assert property (@(posedge clk) disable iff (!rst_n)
    (tx_ready && tx_valid) |=> (drv_p != $past(tx_data))); // R3
  AST_PAIR_COMPLEMENT: assert property (@(posedge clk) disable iff (!rst_n)
    (drv_p == drv_n) |-> (idle_mode && !drv_p)); // R4
  AST_IDLE_POSITIVE: assert property (@(posedge clk) disable iff (!rst_n)
    (tx_ready && !tx_valid) |=> (idle_mode || (drv_p && !drv_n))); // R5
  AST_IDLE_ZERO: assert property (@(posedge clk) disable iff (!rst_n)
    (tx_ready && !tx_valid) |=> (!idle_mode || (!drv_p && !drv_n))); // R6
  AST_DELAYED_TRUE: assert property (@(posedge clk) disable iff (!rst_n)
    warm_ok |-> (drv_pd == hist_p[DLY_TAPS-1])); // R7
  AST_DELAYED_COMP: assert property (@(posedge clk) disable iff (!rst_n)
    warm_ok |-> (drv_nd == hist_n[DLY_TAPS-1])); // R7
  AST_NO_MIDBIT_START: assert property (@(posedge clk) disable iff (!rst_n)
    (!tx_ready && !drv_p && !drv_n) |=> (!drv_p && !drv_n) || !idle_mode); // R8
endmodule

bind manchester_pe_tx manchester_pe_tx_chk #(.DLY_TAPS(DLY_TAPS)) u_chk (.*);

// File: tb/manchester_pe_tx_test.sv
`timescale 1ns/1ps
module manchester_pe_tx_test;
  localparam int CLK_PERIOD = 50;

  logic clk = 1'b0;
  logic rst_n = 1'b0;
  logic idle_mode = 1'b0;
  logic tx_valid = 1'b0;
  logic tx_data = 1'b0;
  logic tx_ready, tx_clk, drv_p, drv_n, drv_pd, drv_nd;

  int  checks = 0;
  int  errors = 0;
  bit  done = 1'b0;
  logic prev_p, prev_n, prev_clk;

  always #(CLK_PERIOD/2) clk = ~clk;

  manchester_pe_tx uut (
    .clk(clk), .rst_n(rst_n), .idle_mode(idle_mode),
    .tx_valid(tx_valid), .tx_data(tx_data), .tx_ready(tx_ready),
    .tx_clk(tx_clk), .drv_p(drv_p), .drv_n(drv_n),
    .drv_pd(drv_pd), .drv_nd(drv_nd)
  );

  task automatic chk(input string req, input logic act, input logic exp);
    checks++;
    if (act !== exp) begin
      errors++;
      $display("FAIL %s actual %0b expected %0b", req, act, exp);
    end
  endtask

  task automatic note_prev();
    prev_p   = drv_p;
    prev_n   = drv_n;
    prev_clk = tx_clk;
  endtask

  // Advance one reference cycle and check per-cycle rules
  task automatic tick();
    @(negedge clk);
    chk("R1 tx_clk toggles each reference cycle", tx_clk, ~prev_clk);
    chk("R2 ready only while tx_clk high", tx_ready & ~tx_clk, 1'b0);
    chk("R7 delayed true line", drv_pd, prev_p);
    chk("R7 delayed complement line", drv_nd, prev_n);
    note_prev();
  endtask

  task automatic wait_ready();
    while (tx_ready !== 1'b1) tick();
  endtask

  task automatic send_bit(input logic d);
    tx_valid = 1'b1;
    tx_data  = d;
    tick();
    chk("R3 first half-bit level", drv_p, ~d);
    chk("R4 complement in first half", drv_n, d);
    chk("R1 tx_clk low in first half", tx_clk, 1'b0);
    chk("R8 ready low in first half", tx_ready, 1'b0);
    tick();
    chk("R3 second half-bit level", drv_p, d);
    chk("R4 complement in second half", drv_n, ~d);
    chk("R2 ready at end of bit", tx_ready, 1'b1);
  endtask

  task automatic end_frame();
    tx_valid = 1'b0;
    for (int k = 0; k < 2; k++) begin
      tick();
      if (idle_mode) begin
        chk("R6 zero-diff idle true", drv_p, 1'b0);
        chk("R6 zero-diff idle comp", drv_n, 1'b0);
      end else begin
        chk("R5 positive idle true", drv_p, 1'b1);
        chk("R5 positive idle comp", drv_n, 1'b0);
      end
    end
  endtask

  task automatic t_reset();
    rst_n = 1'b0;
    repeat (3) @(negedge clk);
    chk("R9 tx_clk in reset", tx_clk, 1'b0);
    chk("R9 ready in reset", tx_ready, 1'b0);
    chk("R9 drv_p in reset", drv_p, 1'b1);
    chk("R9 drv_n in reset", drv_n, 1'b0);
    chk("R9 drv_pd in reset", drv_pd, 1'b1);
    chk("R9 drv_nd in reset", drv_nd, 1'b0);
    rst_n = 1'b1;
    note_prev();
    tick();
    chk("R9 drv_p idle after reset", drv_p, 1'b1);
    chk("R9 drv_n idle after reset", drv_n, 1'b0);
  endtask

  task automatic t_pattern();
    logic [11:0] pat = 12'b1011_0010_1110;
    wait_ready();
    for (int i = 11; i >= 0; i--) send_bit(pat[i]);
    end_frame();
  endtask

  task automatic t_drop_midbit();
    wait_ready();
    send_bit(1'b1);
    tx_valid = 1'b1;
    tx_data  = 1'b0;
    tick();
    chk("R3 zero starts high", drv_p, 1'b1);
    tx_valid = 1'b0;
    tx_data  = 1'b1;
    tick();
    chk("R8 bit finishes after valid drops", drv_p, 1'b0);
    chk("R8 complement finishes", drv_n, 1'b1);
    tick();
    chk("R8 idle at next boundary", drv_p, 1'b1);
    chk("R8 idle comp at next boundary", drv_n, 1'b0);
    tick();
    chk("R8 idle holds", drv_p, 1'b1);
  endtask

  task automatic set_mode(input logic m);
    idle_mode = m;
    #1;
    chk(m ? "R6 idle true follows mode" : "R5 idle true follows mode", drv_p, ~m);
    chk(m ? "R6 idle comp follows mode" : "R5 idle comp follows mode", drv_n, 1'b0);
    note_prev();
  endtask

  task automatic t_zero_diff();
    set_mode(1'b1);
    tick();
    chk("R6 delayed true settles", drv_pd, 1'b0);
    chk("R6 delayed comp settles", drv_nd, 1'b0);
    wait_ready();
    send_bit(1'b0);
    send_bit(1'b0);
    send_bit(1'b1);
    end_frame();
    set_mode(1'b0);
    tick();
    chk("R5 back to positive idle", drv_pd, 1'b1);
  endtask

  initial begin
    t_reset();
    t_pattern();
    t_drop_midbit();
    t_zero_diff();
    done = 1'b1;
    $display("  CHECKS %0d ERRORS %0d", checks, errors);
    $finish;
  end

  initial begin
    repeat (20000) @(posedge clk);
    if (!done) begin
      checks++;
      errors++;
      $display("FAIL watchdog actual timeout expected completion");
      $display("  CHECKS %0d ERRORS %0d", checks, errors);
      $finish;
    end
  end
endmodule